// File: doc/BRIEF.md
# Test Preload and Observe Controller

This block wraps a bank of per-cell state registers in a programmable logic macrocell array and adds two test modes to it. Each mode is entered by a global condition that the logic array produces. The first mode is a parallel load: on a clock edge, every register takes the value on its bidirectional pin, so any present state can be set up directly. The second mode is a view: every pin is forced to drive and shows the raw stored bit of its cell, so buried state machines can be traced.

A lock bit stands for the programmed security cell. While it is set, neither mode can be entered and the cells behave as in normal operation. When neither mode is active, each cell has its normal output path. The pin shows either the array's combinational result or the stored bit, passed through the cell's polarity inversion. The pin enable comes from the cell's normal enable source. The registers clear asynchronously when reset is asserted. The reset release is synchronized to the clock.

Top module: `tpo_ctrl`

## Requirements
- R1: While `load_term_i` is 1 and `lock_i` is 0, a rising clock edge writes `pin_in_i` into every bit of `state_q_o`, whatever the value of `cell_en_i`.
- R2: In normal mode, bit i of `pin_out_o` equals (`comb_sel_i[i]` ? `comb_val_i[i]` : `state_q_o[i]`) XOR `polarity_i[i]`. Here `comb_sel_i` 1 selects the combinational result and `polarity_i` 1 inverts the output. Bit i of `pin_oe_o` equals `oe_i[i]`.
- R3: While `view_term_i` is 1, and `load_term_i` and `lock_i` are both 0, `pin_oe_o` is all ones and `pin_out_o` equals `state_q_o`. This holds whatever the values of `comb_sel_i`, `polarity_i` and `oe_i`.
- R4: View mode does not alter register updates: each register still follows the normal update rule of R7.
- R5: While `lock_i` is 1, `load_term_i` and `view_term_i` have no effect. The registers follow R7 and the pins follow R2.
- R6: When both terms are 1 and the lock is 0, the load takes priority. `pin_oe_o` is all zeros during the load, and `pin_out_o` keeps its normal-mode value.
- R7: Outside a load, a rising clock edge writes `next_d_i[i]` into register i when `cell_en_i[i]` is 1. When `cell_en_i[i]` is 0, the register keeps its value.
- R8: When the block leaves either mode, the pins return to the R2 behaviour in the same cycle, and the loaded state is kept.
- R9: While `rst_ni` is low, `state_q_o` is all zeros and the pins follow R2 with a stored value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_term_i | input | 1 | Global condition for parallel load |
| view_term_i | input | 1 | Global condition for state view |
| lock_i | input | 1 | Security lock; disables both test modes |
| pin_in_i | input | NUM_CELLS | Values present on the bidirectional pins |
| next_d_i | input | NUM_CELLS | Next-state data from the array |
| cell_en_i | input | NUM_CELLS | Per-cell clock enable for normal update |
| comb_sel_i | input | NUM_CELLS | 1 = cell output is combinational |
| comb_val_i | input | NUM_CELLS | Combinational array result per cell |
| polarity_i | input | NUM_CELLS | 1 = inverted (active-low) output |
| oe_i | input | NUM_CELLS | Normal per-cell output enable |
| state_q_o | output | NUM_CELLS | Stored state, fed back to the array |
| pin_out_o | output | NUM_CELLS | Value to drive on each pin |
| pin_oe_o | output | NUM_CELLS | Drive enable for each pin |

## Verification
The assertions assume that the two term inputs and the lock change only between clock edges and are stable at each rising edge. They also assume that reset is applied at the start, so that no check sees unknown values. The bench changes every input on the falling edge and samples one time unit before the next rising edge. It holds the update enables at zero while the reset release moves through the synchronizer.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PRELOAD = 2'd1,
    MODE_OBSERVE = 2'd2
  } tmode_e;
endpackage

// File: rtl/tpo_rst_sync.sv
module tpo_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tpo_mode_decode.sv
module tpo_mode_decode
  import tpo_pkg::*;
(
  input  logic   load_term_i,
  input  logic   view_term_i,
  input  logic   lock_i,
  output tmode_e mode_o
);
  // The lock wins over both terms; the load wins over the view.
  always_comb begin
    if (lock_i)           mode_o = MODE_NORMAL;
    else if (load_term_i) mode_o = MODE_PRELOAD;
    else if (view_term_i) mode_o = MODE_OBSERVE;
    else                  mode_o = MODE_NORMAL;
  end
endmodule

// File: rtl/tpo_state_bank.sv
module tpo_state_bank
  import tpo_pkg::*;
#(
  parameter int NUM_CELLS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  tmode_e               mode_i,
  input  logic [NUM_CELLS-1:0] pin_in_i,
  input  logic [NUM_CELLS-1:0] next_d_i,
  input  logic [NUM_CELLS-1:0] cell_en_i,
  output logic [NUM_CELLS-1:0] state_q_o
);
  logic                 is_load;
  logic [NUM_CELLS-1:0] d_sel;
  logic [NUM_CELLS-1:0] ld_en;

  // Next-state selection and clock enables
  always_comb begin
    is_load = (mode_i == MODE_PRELOAD);
    d_sel   = is_load ? pin_in_i : next_d_i;
    ld_en   = is_load ? {NUM_CELLS{1'b1}} : cell_en_i;
  end

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       state_q_o[g] <= 1'b0;
      else if (ld_en[g]) state_q_o[g] <= d_sel[g];
    end
  end
endmodule

// File: rtl/tpo_pin_mux.sv
module tpo_pin_mux
  import tpo_pkg::*;
#(
  parameter int NUM_CELLS = 16
) (
  input  tmode_e               mode_i,
  input  logic [NUM_CELLS-1:0] state_q_i,
  input  logic [NUM_CELLS-1:0] comb_sel_i,
  input  logic [NUM_CELLS-1:0] comb_val_i,
  input  logic [NUM_CELLS-1:0] polarity_i,
  input  logic [NUM_CELLS-1:0] oe_i,
  output logic [NUM_CELLS-1:0] pin_out_o,
  output logic [NUM_CELLS-1:0] pin_oe_o
);
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    logic norm_val;

    always_comb begin
      norm_val = (comb_sel_i[g] ? comb_val_i[g] : state_q_i[g]) ^ polarity_i[g];
      unique case (mode_i)
        MODE_OBSERVE: begin
          pin_out_o[g] = state_q_i[g];
          pin_oe_o[g]  = 1'b1;
        end
        MODE_PRELOAD: begin
          pin_out_o[g] = norm_val;
          pin_oe_o[g]  = 1'b0;
        end
        default: begin
          pin_out_o[g] = norm_val;
          pin_oe_o[g]  = oe_i[g];
        end
      endcase
    end
  end
endmodule

// File: rtl/tpo_ctrl.sv
module tpo_ctrl
  import tpo_pkg::*;
#(
  parameter int NUM_CELLS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_term_i,
  input  logic                 view_term_i,
  input  logic                 lock_i,
  input  logic [NUM_CELLS-1:0] pin_in_i,
  input  logic [NUM_CELLS-1:0] next_d_i,
  input  logic [NUM_CELLS-1:0] cell_en_i,
  input  logic [NUM_CELLS-1:0] comb_sel_i,
  input  logic [NUM_CELLS-1:0] comb_val_i,
  input  logic [NUM_CELLS-1:0] polarity_i,
  input  logic [NUM_CELLS-1:0] oe_i,
  output logic [NUM_CELLS-1:0] state_q_o,
  output logic [NUM_CELLS-1:0] pin_out_o,
  output logic [NUM_CELLS-1:0] pin_oe_o
);
  logic   rst_sync_n;
  tmode_e mode;

  tpo_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tpo_mode_decode u_mode (
    .load_term_i (load_term_i),
    .view_term_i (view_term_i),
    .lock_i      (lock_i),
    .mode_o      (mode)
  );

  tpo_state_bank #(.NUM_CELLS(NUM_CELLS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .mode_i    (mode),
    .pin_in_i  (pin_in_i),
    .next_d_i  (next_d_i),
    .cell_en_i (cell_en_i),
    .state_q_o (state_q_o)
  );

  tpo_pin_mux #(.NUM_CELLS(NUM_CELLS)) u_mux (
    .mode_i     (mode),
    .state_q_i  (state_q_o),
    .comb_sel_i (comb_sel_i),
    .comb_val_i (comb_val_i),
    .polarity_i (polarity_i),
    .oe_i       (oe_i),
    .pin_out_o  (pin_out_o),
    .pin_oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/tpo_ctrl_chk.sv
module tpo_ctrl_chk #(
  parameter int NUM_CELLS = 16
) (
  input logic                 clk_i,
  input logic                 rst_sync_n,
  input logic                 load_term_i,
  input logic                 view_term_i,
  input logic                 lock_i,
  input logic [NUM_CELLS-1:0] pin_in_i,
  input logic [NUM_CELLS-1:0] next_d_i,
  input logic [NUM_CELLS-1:0] cell_en_i,
  input logic [NUM_CELLS-1:0] oe_i,
  input logic [NUM_CELLS-1:0] state_q_o,
  input logic [NUM_CELLS-1:0] pin_out_o,
  input logic [NUM_CELLS-1:0] pin_oe_o
);
  p_preload_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (load_term_i && !lock_i) |=> (state_q_o == $past(pin_in_i)));

  p_observe_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (view_term_i && !load_term_i && !lock_i) |->
      (pin_oe_o == {NUM_CELLS{1'b1}} && pin_out_o == state_q_o));

  p_lock_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    lock_i |-> (pin_oe_o == oe_i));

  p_preload_release_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (load_term_i && !lock_i) |-> (pin_oe_o == {NUM_CELLS{1'b0}}));

  p_normal_update_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(load_term_i && !lock_i) |=>
      (state_q_o == (($past(cell_en_i) & $past(next_d_i)) |
                     (~$past(cell_en_i) & $past(state_q_o)))));
endmodule

bind tpo_ctrl tpo_ctrl_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_i       (clk_i),
  .rst_sync_n  (rst_sync_n),
  .load_term_i (load_term_i),
  .view_term_i (view_term_i),
  .lock_i      (lock_i),
  .pin_in_i    (pin_in_i),
  .next_d_i    (next_d_i),
  .cell_en_i   (cell_en_i),
  .oe_i        (oe_i),
  .state_q_o   (state_q_o),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o)
);

// File: tb/tpo_ctrl_tb_top.sv
module tpo_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n;
  logic         load_t, view_t, lock;
  logic [N-1:0] pin_in, next_d, cell_en, comb_sel, comb_val, pol, oe;
  logic [N-1:0] state_q, pin_out, pin_oe;

  tpo_ctrl #(.NUM_CELLS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_term_i(load_t), .view_term_i(view_t),
    .lock_i(lock), .pin_in_i(pin_in), .next_d_i(next_d), .cell_en_i(cell_en),
    .comb_sel_i(comb_sel), .comb_val_i(comb_val), .polarity_i(pol), .oe_i(oe),
    .state_q_o(state_q), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  typedef struct {
    logic [N-1:0] out;
    logic [N-1:0] oe;
    logic [N-1:0] q;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [N-1:0] mdl_q;
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 1'b0;

  task automatic cmp(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic step(input logic ld, input logic vw, input logic lk,
                      input logic [N-1:0] pi, input logic [N-1:0] nd,
                      input logic [N-1:0] en, input logic [N-1:0] cs,
                      input logic [N-1:0] cv, input logic [N-1:0] pl,
                      input logic [N-1:0] oev, input string tag);
    exp_t e;
    logic pre_act, obs_act;
    logic [N-1:0] norm;
    @(negedge clk);
    load_t = ld; view_t = vw; lock = lk; pin_in = pi; next_d = nd;
    cell_en = en; comb_sel = cs; comb_val = cv; pol = pl; oe = oev;
    pre_act = ld && !lk;
    obs_act = vw && !lk && !pre_act;
    norm    = ((cs & cv) | (~cs & mdl_q)) ^ pl;
    e.q   = mdl_q;
    e.tag = tag;
    if (pre_act) begin
      e.out = norm;     e.oe = '0;
    end else if (obs_act) begin
      e.out = mdl_q;    e.oe = '1;
    end else begin
      e.out = norm;     e.oe = oev;
    end
    sb_q.push_back(e);
    mdl_q = pre_act ? pi : ((en & nd) | (~en & mdl_q));
  endtask

  // Monitor: samples one time unit before the rising edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/2 - 1);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        cmp(e.tag, "state", state_q, e.q);
        cmp(e.tag, "pin_out", pin_out, e.out);
        cmp(e.tag, "pin_oe", pin_oe, e.oe);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_t = 0; view_t = 0; lock = 0;
    pin_in = '0; next_d = '1; cell_en = '1; comb_sel = '0;
    comb_val = '0; pol = '0; oe = 16'hA5A5;
    mdl_q = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset clears state even with enables high; pins use stored zero
    cmp("R9", "state", state_q, '0);
    cmp("R9", "pin_out", pin_out, '0);
    cmp("R9", "pin_oe", pin_oe, 16'hA5A5);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, '0, '0, '0, '0, '0, '0, 16'hA5A5, "R9 release");

    // R7 normal update with partial enables; R2 output path
    step(0, 0, 0, '0, 16'hF0F0, 16'hFF00, 16'h0000, 16'h0, 16'h0000, 16'hFFFF, "R7 load some");
    step(0, 0, 0, '0, 16'h0F0F, 16'h00FF, 16'h0000, 16'h0, 16'h3C3C, 16'h0F0F, "R7 R2 polarity");
    step(0, 0, 0, '0, 16'h0000, 16'h0000, 16'h00FF, 16'h5555, 16'h0F00, 16'hFFFF, "R2 comb mix");

    // R1 preload ignores cell_en and next_d
    step(1, 0, 0, 16'h1234, 16'hFFFF, 16'h0000, 16'h00FF, 16'hAAAA, 16'h0000, 16'hFFFF, "R1 preload");
    // R8 leave preload: state kept, pins normal, polarity applied
    step(0, 0, 0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'hFF00, 16'hFFFF, "R8 after preload");
    step(0, 0, 0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h0000, 16'h00FF, "R2 R8 hold");

    // R3 observe overrides comb/polarity/enable; R4 updates still happen
    step(0, 1, 0, '0, 16'hABCD, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, "R3 R4 observe");
    step(0, 1, 0, '0, 16'h0000, 16'h00F0, 16'h0F0F, 16'hFFFF, 16'h0000, 16'h0000, "R3 R4 observe2");
    step(0, 0, 0, '0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1111, "R8 after observe");

    // R6 both terms: preload wins, pins released
    step(1, 1, 0, 16'h5A5A, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h0000, 16'hFFFF, "R6 both");
    step(0, 0, 0, '0, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h0000, 16'hFFFF, "R6 result");

    // R5 lock blocks both modes
    step(1, 0, 1, 16'hFFFF, 16'h0001, 16'h000F, 16'h0000, 16'h0, 16'h0000, 16'h0000, "R5 lock load");
    step(0, 1, 1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h00FF, 16'h0F0F, "R5 lock view");
    step(1, 1, 1, 16'hFFFF, 16'h8000, 16'h8000, 16'h0000, 16'h0, 16'h0000, 16'h3333, "R5 lock both");
    step(0, 0, 0, '0, 16'h0000, 16'h0000, 16'h0000, 16'h0, 16'h0000, 16'h0000, "R5 after lock");

    // Mixed random traffic across all modes
    for (int i = 0; i < 400; i++) begin
      logic ld, vw, lk;
      string t;
      ld = ($urandom % 4) == 0;
      vw = ($urandom % 3) == 0;
      lk = ($urandom % 5) == 0;
      if (lk)           t = "R5 rnd";
      else if (ld && vw) t = "R6 rnd";
      else if (ld)      t = "R1 rnd";
      else if (vw)      t = "R3 rnd";
      else              t = "R2 R7 rnd";
      step(ld, vw, lk, N'($urandom), N'($urandom), N'($urandom), N'($urandom),
           N'($urandom), N'($urandom), N'($urandom), t);
    end

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule